// File: doc/BRIEF.md
# Interrupt routing table locator

The locator hunts for an interrupt routing table inside the firmware ROM window that runs from 0xF0000 up to, but not including, 0x100000. It uses one byte-wide synchronous read port to memory. The port takes an address and a request strobe, and it answers with a data byte and a valid strobe one or more cycles later. The block never writes memory. It looks at candidate positions one after another on 16-byte boundaries. For each candidate it filters in stages: the 4-byte signature first, then the 16-bit version, then the rules on the declared size. A candidate that fails any stage is dropped at the first bad byte.

Only a candidate that clears all three stages has every byte of its declared length added into an 8-bit wrapping sum. The header bytes it has already read count toward that sum. If the sum comes out zero, the search stops and reports the table. If it does not, the scan carries on at the next 16-byte boundary after that candidate. When the window runs out, the block reports a miss.

Software or a boot sequencer pulses `start`. It then waits for the one-cycle `done` pulse and reads `found`, `base_addr` and `table_size`. Those outputs hold until the next scan completes.

Top module: `irq_rtab_locator`

## Requirements
- R1: After `start` in idle, the first read request is at 0xF0000. Every candidate base is 16-byte aligned, at least 0xF0000 and below 0x100000, and a rejected candidate moves the base on by 16.
- R2: Bytes at candidate offsets 0,1,2,3 must be 0x24,0x50,0x49,0x52. The first mismatching byte rejects the candidate, and no further byte of that candidate is read, so an all-zero window costs exactly 4096 reads.
- R3: The version at offsets 4 (low byte) and 5 (high byte) must read 0x0100. Any other value rejects the candidate.
- R4: The size at offsets 6 (low byte) and 7 (high byte) must be a multiple of 16 and no less than 32. Sizes such as 40 or 16 reject the candidate.
- R5: A candidate that passes the header is accepted only if the 8-bit wrapping sum of its first `size` bytes, header included, is zero. If the sum is not zero, the scan resumes at that candidate's base + 16.
- R6: The lowest-addressed candidate that passes every check ends the search, and its base and size are reported.
- R7: `busy` is high from the cycle after an accepted `start` until the scan ends. `done` is high for exactly one cycle, with `busy` low in that cycle. `found`, `base_addr` and `table_size` change only together with `done`.
- R8: When no candidate passes, `done` comes with `found`=0, `base_addr`=0 and `table_size`=0.
- R9: At most one read is outstanding. After a request, no new request is issued until the valid strobe returns.
- R10: A `start` pulse while `busy` is high has no effect. The scan ends in the same cycle and with the same result as without that pulse.
- R11: After reset, `busy`, `done`, `found` and `mem_req` are 0, and `base_addr` and `table_size` are 0.
- R12: Tables at the first candidate (0xF0000) and at the last candidate (0xFFFF0) are both found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan; honoured only in idle |
| mem_req | output | 1 | One-cycle read request strobe |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A table was located |
| base_addr | output | 32 | Base of the located table, 0 on a miss |
| table_size | output | 16 | Declared size of the located table, 0 on a miss |

## Verification
The hardest case to reach is a candidate that clears all three header stages, fails only on its checksum, and has a good table starting exactly 16 bytes above it. That case is the only way to tell a resume at base + 16 apart from a skip over the declared length. The bench builds the two tables so they overlap. It then computes the sum of the bad candidate's span from memory and nudges one gap byte that only the bad table covers until that sum is non-zero. A second hard case is a restart during a scan. The bench pulses `start` mid-scan and compares the cycle at which `done` arrives against an undisturbed reference run.

// File: rtl/irq_rtab_pkg.sv
package irq_rtab_pkg;

  // width of the declared size field
  localparam int unsigned SIZE_W      = 16;
  // signature plus version bytes compared against constants
  localparam int unsigned KEY_BYTES   = 6;
  // signature, version and size bytes of the header
  localparam int unsigned FIELD_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } scan_st_t;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_NEXT_BYTE,
    EV_REJECT,
    EV_ACCEPT
  } byte_ev_t;

endpackage

// File: rtl/irq_rtab_cursor.sv
module irq_rtab_cursor
  import irq_rtab_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]     WIN_BASE = 32'h000F_0000,
  parameter logic [ADDR_W-1:0]     WIN_END  = 32'h0010_0000,
  parameter int unsigned           STRIDE   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              step,
  output logic [ADDR_W-1:0] base_q,
  output logic [SIZE_W-1:0] off_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] LAST_BASE = WIN_END - ADDR_W'(STRIDE);
  localparam int unsigned       ALIGN_W   = $clog2(STRIDE);

  logic [ADDR_W-1:0] base_d;
  logic [SIZE_W-1:0] off_d;
  logic              base_en;
  logic              off_en;

  always_comb begin
    base_en = load | adv;
    off_en  = load | adv | step;
    base_d  = base_q;
    off_d   = off_q;
    if (load) begin
      base_d = WIN_BASE;
      off_d  = '0;
    end else if (adv) begin
      base_d = base_q + ADDR_W'(STRIDE);
      off_d  = '0;
    end else if (step) begin
      off_d  = off_q + SIZE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= WIN_BASE;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_d;
    end
  end

  assign rd_addr = base_q + ADDR_W'(off_q);
  assign last    = (base_q == LAST_BASE);

  AST_BASE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q >= WIN_BASE) && (base_q < WIN_END) && (base_q[ALIGN_W-1:0] == '0)); // R1

endmodule

// File: rtl/irq_rtab_hdr_filter.sv
module irq_rtab_hdr_filter
  import irq_rtab_pkg::*;
#(
  parameter logic [31:0] SIG     = 32'h5249_5024,
  parameter logic [15:0] VER     = 16'h0100,
  parameter int unsigned HDR_LEN = 32,
  parameter int unsigned STRIDE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [2:0]        idx,
  input  logic [7:0]        data,
  output logic              fail,
  output logic [SIZE_W-1:0] size_q
);

  localparam int unsigned          ALIGN_W = $clog2(STRIDE);
  localparam logic [8*KEY_BYTES-1:0] KEY   = {VER, SIG};

  logic [KEY_BYTES-1:0] key_hit;
  logic [7:0]           lo_q;
  logic [7:0]           lo_d;
  logic [SIZE_W-1:0]    size_now;
  logic [SIZE_W-1:0]    size_d;
  logic                 size_bad;
  logic                 fail_c;
  logic                 lo_en;
  logic                 size_en;

  // one comparator per constant header byte
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
    assign key_hit[g] = (data == KEY[8*g +: 8]);
  end

  always_comb begin
    size_now = {data, lo_q};
    size_bad = (size_now[ALIGN_W-1:0] != '0) || (size_now < SIZE_W'(HDR_LEN));
    if (idx < 3'(KEY_BYTES)) begin
      fail_c = ~key_hit[idx];
    end else if (idx == 3'(FIELD_BYTES - 1)) begin
      fail_c = size_bad;
    end else begin
      fail_c = 1'b0;
    end
    lo_en   = vld && (idx == 3'(KEY_BYTES));
    size_en = vld && (idx == 3'(FIELD_BYTES - 1));
    lo_d    = data;
    size_d  = size_now;
  end

  assign fail = vld & fail_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
    end else if (size_en) begin
      size_q <= size_d;
    end
  end

endmodule

// File: rtl/irq_rtab_sum.sv
module irq_rtab_sum #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] data,
  output logic [W-1:0] sum_q,
  output logic         zero_next
);

  logic [W-1:0] sum_d;
  logic [W-1:0] sum_plus;
  logic         sum_en;

  always_comb begin
    sum_plus = sum_q + data;
    sum_en   = clr | add;
    sum_d    = clr ? '0 : sum_plus;
  end

  assign zero_next = (sum_plus == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

endmodule

// File: rtl/irq_rtab_locator.sv
module irq_rtab_locator
  import irq_rtab_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000F_0000,
  parameter logic [ADDR_W-1:0] WIN_END  = 32'h0010_0000,
  parameter int unsigned       STRIDE   = 16,
  parameter int unsigned       HDR_LEN  = 32,
  parameter logic [31:0]       SIG      = 32'h5249_5024,
  parameter logic [15:0]       VER      = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] base_addr,
  output logic [SIZE_W-1:0] table_size
);

  localparam int unsigned ALIGN_W = $clog2(STRIDE);

  scan_st_t          st_q;
  scan_st_t          st_d;
  byte_ev_t          ev;
  logic [ADDR_W-1:0] cur_base;
  logic [SIZE_W-1:0] cur_off;
  logic [ADDR_W-1:0] rd_addr;
  logic              last_cand;
  logic              in_hdr;
  logic              tbl_end;
  logic              hdr_vld;
  logic              hdr_fail;
  logic [SIZE_W-1:0] hdr_size;
  logic [7:0]        sum_q;
  logic              sum_zero_next;
  logic              c_load;
  logic              c_adv;
  logic              c_step;
  logic              s_clr;
  logic              s_add;
  logic              finish;
  logic              done_d;
  logic              found_d;
  logic [ADDR_W-1:0] base_res_d;
  logic [SIZE_W-1:0] size_res_d;

  irq_rtab_cursor #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_END  (WIN_END),
    .STRIDE   (STRIDE)
  ) cursor_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (c_load),
    .adv     (c_adv),
    .step    (c_step),
    .base_q  (cur_base),
    .off_q   (cur_off),
    .rd_addr (rd_addr),
    .last    (last_cand)
  );

  irq_rtab_hdr_filter #(
    .SIG     (SIG),
    .VER     (VER),
    .HDR_LEN (HDR_LEN),
    .STRIDE  (STRIDE)
  ) filter_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (hdr_vld),
    .idx    (cur_off[2:0]),
    .data   (mem_rdata),
    .fail   (hdr_fail),
    .size_q (hdr_size)
  );

  irq_rtab_sum #(
    .W (8)
  ) sum_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (s_clr),
    .add       (s_add),
    .data      (mem_rdata),
    .sum_q     (sum_q),
    .zero_next (sum_zero_next)
  );

  // classify the byte that has just arrived
  always_comb begin
    in_hdr  = (cur_off < SIZE_W'(FIELD_BYTES));
    tbl_end = (cur_off == (hdr_size - SIZE_W'(1)));
    hdr_vld = (st_q == ST_WAIT) && mem_rvalid && in_hdr;
    ev      = EV_NONE;
    if ((st_q == ST_WAIT) && mem_rvalid) begin
      if (in_hdr) begin
        ev = hdr_fail ? EV_REJECT : EV_NEXT_BYTE;
      end else if (tbl_end) begin
        ev = sum_zero_next ? EV_ACCEPT : EV_REJECT;
      end else begin
        ev = EV_NEXT_BYTE;
      end
    end
  end

  // control of the datapath pieces
  always_comb begin
    c_load = (st_q == ST_IDLE) && start;
    c_adv  = (ev == EV_REJECT) && !last_cand;
    c_step = (ev == EV_NEXT_BYTE);
    s_clr  = c_load || (ev == EV_REJECT);
    s_add  = (ev == EV_NEXT_BYTE);
    finish = (ev == EV_ACCEPT) || ((ev == EV_REJECT) && last_cand);
  end

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: begin
        case (ev)
          EV_NEXT_BYTE: st_d = ST_REQ;
          EV_REJECT:    st_d = last_cand ? ST_IDLE : ST_REQ;
          EV_ACCEPT:    st_d = ST_IDLE;
          default:      st_d = ST_WAIT;
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // result next values
  always_comb begin
    done_d     = finish;
    found_d    = found;
    base_res_d = base_addr;
    size_res_d = table_size;
    if (finish) begin
      found_d    = (ev == EV_ACCEPT);
      base_res_d = (ev == EV_ACCEPT) ? cur_base : '0;
      size_res_d = (ev == EV_ACCEPT) ? hdr_size : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found      <= 1'b0;
      base_addr  <= '0;
      table_size <= '0;
    end else if (finish) begin
      found      <= found_d;
      base_addr  <= base_res_d;
      table_size <= size_res_d;
    end
  end

  assign mem_req  = (st_q == ST_REQ);
  assign mem_addr = rd_addr;
  assign busy     = (st_q != ST_IDLE);

  AST_FIRST_READ_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mem_req && (mem_addr == WIN_BASE))); // R1

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found) && $stable(base_addr) && $stable(table_size))); // R7

  AST_FOUND_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> ((base_addr[ALIGN_W-1:0] == '0) && (table_size[ALIGN_W-1:0] == '0)
                         && (table_size >= SIZE_W'(HDR_LEN)))); // R4

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> ((base_addr == '0) && (table_size == '0))); // R8

endmodule

// File: tb/irq_rtab_locator_tb_top.sv
`timescale 1ns/1ps
module irq_rtab_locator_tb_top;

  localparam int WD_LIMIT = 195000;

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] size;
    logic [2:0]  kind;   // 0 good, 1 bad signature, 2 bad version, 3 bad size, 4 bad sum
    logic        exp_found;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h000F_0000, 16'd32,  3'd0, 1'b1},
    '{32'h000F_FFF0, 16'd32,  3'd0, 1'b1},
    '{32'h000F_8A50, 16'd256, 3'd0, 1'b1},
    '{32'h000F_1230, 16'd48,  3'd1, 1'b0},
    '{32'h000F_4000, 16'd64,  3'd2, 1'b0},
    '{32'h000F_2000, 16'd40,  3'd3, 1'b0},
    '{32'h000F_3000, 16'd16,  3'd3, 1'b0},
    '{32'h000F_5000, 16'd32,  3'd4, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [7:0]  mem_rdata;
  logic        busy;
  logic        done;
  logic        found;
  logic [31:0] base_addr;
  logic [15:0] table_size;

  int checks = 0;
  int fails = 0;
  int cyc_cnt = 0;
  int req_cnt = 0;
  int ovl_cnt = 0;

  logic [7:0] mem [logic [31:0]];

  logic       v1 = 1'b0, v2 = 1'b0;
  logic [7:0] d1 = 8'h00, d2 = 8'h00;
  logic       outst = 1'b0;

  always #4 clk = ~clk;

  irq_rtab_locator dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .base_addr  (base_addr),
    .table_size (table_size)
  );

  function automatic logic [7:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  // two-cycle latency memory model
  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (mem_req) begin
      req_cnt <= req_cnt + 1;
      if (outst) ovl_cnt <= ovl_cnt + 1;
    end
    if (mem_req) outst <= 1'b1;
    else if (v2) outst <= 1'b0;
    v1 <= mem_req;
    d1 <= rd(mem_addr);
    v2 <= v1;
    d2 <= d1;
  end
  assign mem_rvalid = v2;
  assign mem_rdata  = d2;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic place(input logic [31:0] a, input logic [15:0] sz, input logic [2:0] kind);
    logic [7:0] s;
    for (int i = 0; i < int'(sz); i++) mem[a + 32'(i)] = 8'((i * 7 + 3) & 255);
    mem[a + 0] = 8'h24; mem[a + 1] = 8'h50; mem[a + 2] = 8'h49; mem[a + 3] = 8'h52;
    mem[a + 4] = 8'h00; mem[a + 5] = 8'h01;
    mem[a + 6] = sz[7:0]; mem[a + 7] = sz[15:8];
    s = 8'h00;
    for (int i = 0; i < int'(sz); i++) if (i != 8) s = s + rd(a + 32'(i));
    mem[a + 8] = 8'h00 - s;
    case (kind)
      3'd1: mem[a + 2] = 8'h48;
      3'd2: mem[a + 5] = 8'h02;
      3'd4: mem[a + 9] = rd(a + 9) + 8'h01;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] span_sum(input logic [31:0] a, input int n);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < n; i++) s = s + rd(a + 32'(i));
    return s;
  endfunction

  function automatic string kind_req(input logic [2:0] k, input logic [31:0] a);
    case (k)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return (a == 32'h000F_0000 || a == 32'h000F_FFF0) ? "R12" : "R6";
    endcase
  endfunction

  task automatic run_scan(input logic mid_start, output logic f, output logic [31:0] b,
                          output logic [15:0] s, output int cyc, output int reqs,
                          output logic busy_seen, output int done_len);
    int r0;
    r0 = req_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    busy_seen = busy;
    cyc = 1;
    while (!done) begin
      if (mid_start && cyc == 40) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    f = found; b = base_addr; s = table_size;
    chk("R7", {31'd0, busy}, 32'd0);
    done_len = 0;
    for (int k = 0; k < 4; k++) begin
      if (done) done_len++;
      @(negedge clk);
    end
    chk("R7", {31'd0, found}, {31'd0, f});
    chk("R7", base_addr, b);
    reqs = req_cnt - r0;
  endtask

  initial begin
    @(posedge clk);
    while (cyc_cnt < WD_LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc_cnt, WD_LIMIT);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic f;
    logic [31:0] b;
    logic [15:0] s;
    int cyc, reqs, dlen, cyc_ref;
    logic bs;

    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", {31'd0, busy}, 32'd0);
    chk("R11", {31'd0, done}, 32'd0);
    chk("R11", {31'd0, found}, 32'd0);
    chk("R11", {31'd0, mem_req}, 32'd0);
    chk("R11", base_addr, 32'd0);
    chk("R11", {16'd0, table_size}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table
    for (int v = 0; v < 8; v++) begin
      mem.delete();
      place(VECS[v].addr, VECS[v].size, VECS[v].kind);
      run_scan(1'b0, f, b, s, cyc, reqs, bs, dlen);
      chk(kind_req(VECS[v].kind, VECS[v].addr), {31'd0, f}, {31'd0, VECS[v].exp_found});
      chk(VECS[v].exp_found ? "R6" : "R8", b, VECS[v].exp_found ? VECS[v].addr : 32'd0);
      chk(VECS[v].exp_found ? "R6" : "R8", {16'd0, s},
          VECS[v].exp_found ? {16'd0, VECS[v].size} : 32'd0);
      if (v == 0) begin
        chk("R7", {31'd0, bs}, 32'd1);
        chk("R7", dlen, 1);
        chk("R1", reqs, 32);
      end
    end

    // R2 empty window: one read per candidate
    mem.delete();
    run_scan(1'b0, f, b, s, cyc, reqs, bs, dlen);
    chk("R2", reqs, 4096);
    chk("R8", {31'd0, f}, 32'd0);
    chk("R9", ovl_cnt, 0);

    // R5 bad sum candidate with a good table 16 bytes above
    mem.delete();
    place(32'h000F_0100, 16'd32, 3'd0);
    place(32'h000F_0110, 16'd32, 3'd0);
    if (span_sum(32'h000F_0100, 32) == 8'h00) mem[32'h000F_010C] = rd(32'h000F_010C) + 8'h01;
    run_scan(1'b0, f, b, s, cyc, reqs, bs, dlen);
    chk("R5", {31'd0, f}, 32'd1);
    chk("R5", b, 32'h000F_0110);
    chk("R5", {16'd0, s}, 32'd32);

    // R6 two good tables, lower wins
    mem.delete();
    place(32'h000F_0800, 16'd64, 3'd0);
    place(32'h000F_0400, 16'd32, 3'd0);
    run_scan(1'b0, f, b, s, cyc, reqs, bs, dlen);
    chk("R6", b, 32'h000F_0400);
    chk("R6", {16'd0, s}, 32'd32);

    // R10 start while busy
    mem.delete();
    place(32'h000F_0600, 16'd48, 3'd0);
    run_scan(1'b0, f, b, s, cyc_ref, reqs, bs, dlen);
    run_scan(1'b1, f, b, s, cyc, reqs, bs, dlen);
    chk("R10", cyc, cyc_ref);
    chk("R10", b, 32'h000F_0600);
    chk("R10", dlen, 1);
    chk("R10", {31'd0, busy}, 32'd0);
    chk("R9", ovl_cnt, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule